// File: doc/BRIEF.md
# Microwire EEPROM Command Controller

This block is a host-side master for a byte-organised serial EEPROM with a three-wire Microwire-style link. Software or a sequencer gives it a command code, an address and a write byte, then pulses a start input. The block frames the command as a start bit, a two-bit opcode and the address field, most significant bit first. For commands that move data it adds eight data bits. It drives chip select, the serial clock and the serial data line, and it samples the device's data output.

READ places the received byte in a holding register. WRITE, ERASE, write-all and erase-all are programming commands. After one of these, the block deselects the device for a short gap, selects it again and watches the device's data output until the device reports ready. If ready does not arrive within a fixed time budget, a sticky timeout flag is raised. The enable and disable commands for programming share opcode 00 with write-all and erase-all, and the two top address bits tell the four apart. The address width is a parameter and may be 9 or 11 bits. The serial clock is the system clock divided by a parameter.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ee_cs`, `ee_sclk`, `ee_mosi`, `busy` and `timeout` are low and `rdata` is zero.
- R2: Each frame begins with a 1 and then a two-bit opcode, followed by the ADDR_W-bit address with the MSB first. The `cmd_op` codes map as follows: 0 is READ (opcode 10), 1 is WRITE (01), 2 is ERASE (11), 3 is enable (00, top address bits 11), 4 is disable (00, top bits 00), 5 is write-all (00, top bits 01) and 6 is erase-all (00, top bits 10). For the opcode-00 commands, the address bits below the top two are sent as 0.
- R3: Enable, disable, ERASE and erase-all frames last 3+ADDR_W serial clocks, which is 12 when ADDR_W is 9. READ, WRITE and write-all frames last 11+ADDR_W clocks, which is 20 when ADDR_W is 9.
- R4: WRITE and write-all send `cmd_wdata` after the address, bit 7 first.
- R5: READ samples `ee_miso` on the rising serial edge of the eight clocks that follow the address, bit 7 first. `ee_mosi` stays low through those eight clocks. The byte is loaded into `rdata` in the same cycle that `busy` falls.
- R6: `ee_mosi` changes only while `ee_sclk` is low, so it holds steady across every rising edge.
- R7: After a programming command, `ee_cs` stays low for 2*CLK_DIV system clocks, which is one serial clock period. It then rises, and `busy` stays high until `ee_miso` is sampled high.
- R8: If `ee_miso` stays low for TIMEOUT_MS milliseconds of polling, computed from CLK_HZ, then `timeout` is set, `busy` falls and `ee_cs` drops. `timeout` is cleared by the next accepted command.
- R9: `busy` rises the cycle after an accepted `cmd_go` and stays high until the command completes. A `cmd_go` that arrives while `busy` is high is ignored.
- R10: A `cmd_go` with `cmd_op` equal to 7 is ignored: no frame is sent and `busy` stays low.
- R11: Each half period of `ee_sclk` lasts CLK_DIV system clocks, counted from the rise of `ee_cs`. `ee_sclk` is low whenever `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_go | input | 1 | Start pulse for the command on the command inputs |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 8 | Byte for WRITE and write-all |
| busy | output | 1 | Command in progress |
| timeout | output | 1 | Sticky ready-poll timeout flag |
| rdata | output | 8 | Byte returned by the last READ |
| ee_cs | output | 1 | Device chip select |
| ee_sclk | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data and ready/busy from the device |

## Verification
The properties assume three things about the inputs. First, `cmd_go` is sampled on `clk` and lasts a single cycle. Second, `ee_miso` is already synchronous to `clk`. Third, the device moves `ee_miso` only after a serial falling edge or a change of select. The bench meets these conditions with a behavioural device model that is updated on the opposite clock edge. The model changes its read bit only after falling edges, drives ready/busy only while it is selected, and can be held busy for good to force the timeout.

// File: rtl/mw_pkg.sv
// Shared types and command-decoding helpers for the Microwire EEPROM
// controller. Assumes the command codes listed in the block's brief.
package mw_pkg;

    // Command codes seen on cmd_op.
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_EWEN  = 3'd3,
        OP_EWDS  = 3'd4,
        OP_WRAL  = 3'd5,
        OP_ERAL  = 3'd6,
        OP_RSVD  = 3'd7
    } mw_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_POLL
    } mw_state_e;

    // Two-bit opcode placed after the start bit.
    function automatic logic [1:0] op_code(input mw_op_e op);
        case (op)
            OP_READ:  return 2'b10;
            OP_WRITE: return 2'b01;
            OP_ERASE: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

    // Top two address bits that select among the opcode-00 commands.
    function automatic logic [1:0] op_subcode(input mw_op_e op);
        case (op)
            OP_EWEN: return 2'b11;
            OP_WRAL: return 2'b01;
            OP_ERAL: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // Frame carries an eight-bit data phase.
    function automatic logic op_long(input mw_op_e op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

    // Host drives the data phase.
    function automatic logic op_sends_data(input mw_op_e op);
        return (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

    // Command starts an internal programming cycle.
    function automatic logic op_programs(input mw_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_WRAL)  || (op == OP_ERAL);
    endfunction

endpackage

// File: rtl/mw_tick_gen.sv
// Serial clock phase divider. While run is high it pulses tick once every
// DIV system clocks; each tick is one half period of the serial clock.
// Assumes DIV >= 1. The count restarts whenever run is low.
module mw_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    // Count system clocks inside one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == W'(DIV - 1));
endmodule

// File: rtl/mw_shift.sv
// Transmit and receive shift registers for one frame. The transmit side
// sends the MSB of a left-justified frame and shifts in zeros. The receive
// side keeps the last eight sampled bits. Assumes load, tx_shift and
// rx_sample come from the sequencer and never overlap with load.
module mw_shift #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tx_shift,
    input  logic         rx_sample,
    input  logic         rx_bit,
    output logic         tx_bit,
    output logic [7:0]   rx_byte
);
    logic [W-1:0] tx_sr;
    logic [7:0]   rx_sr;

    // Outgoing frame, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_val;
        end else if (tx_shift) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
    end

    // Incoming bits, newest in the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (load) begin
            rx_sr <= '0;
        end else if (rx_sample) begin
            rx_sr <= {rx_sr[6:0], rx_bit};
        end
    end

    assign tx_bit  = tx_sr[W-1];
    assign rx_byte = rx_sr;
endmodule

// File: rtl/mw_poll_timer.sv
// Ready-poll budget. It counts system clocks while run is high and raises
// expired on the LIMIT-th cycle of a run. Assumes LIMIT >= 1. The count
// clears when run drops.
module mw_poll_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    // Count polling cycles and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != W'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Microwire EEPROM command controller (top).
// It accepts one command per cmd_go pulse while idle, shifts out the frame
// with ee_mosi changing on serial falling edges and ee_miso sampled on
// rising edges, and loads the READ byte into rdata. After a programming
// command it deselects the device for one serial period, reselects it and
// polls ee_miso for ready within a time budget.
// Assumptions: ADDR_W is 9 or 11; ee_miso is synchronous to clk;
// CLK_HZ is a multiple of 1000.
module mw_eeprom_ctrl #(
    parameter int ADDR_W     = 9,
    parameter int CLK_DIV    = 2,
    parameter int CLK_HZ     = 250_000_000,
    parameter int TIMEOUT_MS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              timeout,
    output logic [7:0]        rdata,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_mosi,
    input  logic              ee_miso
);
    import mw_pkg::*;

    localparam int CMD_W       = 3 + ADDR_W;
    localparam int FRAME_W     = CMD_W + 8;
    localparam int CNT_W       = $clog2(FRAME_W);
    localparam int TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

    mw_state_e          state;
    mw_op_e             op_q;
    mw_op_e             req_op;
    logic               long_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   last_idx;
    logic               gap_half;
    logic               cs_q;
    logic               sclk_q;
    logic               busy_q;
    logic               to_q;
    logic [7:0]         rdata_q;
    logic               accept;
    logic               tick;
    logic               tick_run;
    logic               expired;
    logic               tx_bit;
    logic [7:0]         rx_byte;
    logic [ADDR_W-1:0]  addr_f;
    logic [7:0]         data_f;
    logic [FRAME_W-1:0] frame;

    // Decode the requested command and build its left-justified frame.
    always_comb begin
        req_op = mw_op_e'(cmd_op);
        addr_f = cmd_addr;
        if (op_code(req_op) == 2'b00) begin
            addr_f = {op_subcode(req_op), {(ADDR_W - 2){1'b0}}};
        end
        data_f = op_sends_data(req_op) ? cmd_wdata : 8'h00;
        frame  = {1'b1, op_code(req_op), addr_f, data_f};
    end

    assign accept   = (state == ST_IDLE) && cmd_go && (req_op != OP_RSVD);
    assign last_idx = long_q ? CNT_W'(FRAME_W - 1) : CNT_W'(CMD_W - 1);
    assign tick_run = (state == ST_SHIFT) || (state == ST_GAP);

    mw_tick_gen #(
        .DIV (CLK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_run),
        .tick  (tick)
    );

    mw_shift #(
        .W (FRAME_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (frame),
        .tx_shift  (tick && (state == ST_SHIFT) && sclk_q),
        .rx_sample (tick && (state == ST_SHIFT) && !sclk_q),
        .rx_bit    (ee_miso),
        .tx_bit    (tx_bit),
        .rx_byte   (rx_byte)
    );

    mw_poll_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_POLL),
        .expired (expired)
    );

    // Command sequencer: frame shifting, deselect gap, ready polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_READ;
            long_q   <= 1'b0;
            bit_cnt  <= '0;
            gap_half <= 1'b0;
            cs_q     <= 1'b0;
            sclk_q   <= 1'b0;
            busy_q   <= 1'b0;
            to_q     <= 1'b0;
            rdata_q  <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= req_op;
                        long_q  <= op_long(req_op);
                        bit_cnt <= '0;
                        cs_q    <= 1'b1;
                        sclk_q  <= 1'b0;
                        busy_q  <= 1'b1;
                        to_q    <= 1'b0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_cnt == last_idx) begin
                                cs_q <= 1'b0;
                                if (op_programs(op_q)) begin
                                    gap_half <= 1'b0;
                                    state    <= ST_GAP;
                                end else begin
                                    busy_q <= 1'b0;
                                    state  <= ST_IDLE;
                                    if (op_q == OP_READ) begin
                                        rdata_q <= rx_byte;
                                    end
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            cs_q  <= 1'b1;
                            state <= ST_POLL;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (ee_miso) begin
                        cs_q   <= 1'b0;
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else if (expired) begin
                        to_q   <= 1'b1;
                        cs_q   <= 1'b0;
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy    = busy_q;
    assign timeout = to_q;
    assign rdata   = rdata_q;
    assign ee_cs   = cs_q;
    assign ee_sclk = sclk_q;
    assign ee_mosi = tx_bit;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
// Property checker for mw_eeprom_ctrl, attached by bind. It observes the
// ports only and assumes cmd_go and ee_miso are synchronous to clk.
module mw_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_go,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       timeout,
    input logic       ee_cs,
    input logic       ee_sclk,
    input logic       ee_mosi
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!ee_cs && !ee_sclk && !busy && !timeout));

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> $stable(ee_mosi));

    // R11
    sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sclk);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_go));

    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ee_cs) && busy) |=> !ee_cs);

    // R8
    timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($fell(busy) && !ee_cs));

    // R10
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go && cmd_op == 3'd7) |=> !busy);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_go  (cmd_go),
    .cmd_op  (cmd_op),
    .busy    (busy),
    .timeout (timeout),
    .ee_cs   (ee_cs),
    .ee_sclk (ee_sclk),
    .ee_mosi (ee_mosi)
);

// File: tb/mw_eeprom_ctrl_bench.sv
// Directed bench for mw_eeprom_ctrl with a behavioural serial EEPROM model.
module mw_eeprom_ctrl_bench;
    localparam int AW   = 9;
    localparam int DIV  = 2;
    localparam int TO   = 600;   // 20 kHz model clock rate * 30 ms
    localparam int BSY  = 50;
    localparam int CW   = 3 + AW;
    localparam int FW   = CW + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_go = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_wdata = 8'h00;
    logic          busy, timeout, cs, sclk, sdo, sdi;
    logic [7:0]    rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mw_eeprom_ctrl #(
        .ADDR_W     (AW),
        .CLK_DIV    (DIV),
        .CLK_HZ     (20_000),
        .TIMEOUT_MS (30)
    ) u_mw_eeprom_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .timeout   (timeout),
        .rdata     (rdata),
        .ee_cs     (cs),
        .ee_sclk   (sclk),
        .ee_mosi   (sdo),
        .ee_miso   (sdi)
    );

    // ---------------- device model (updated on the falling clk edge) ----
    logic [7:0]    mem [0:(1<<AW)-1];
    logic [FW-1:0] fr = '0, last_fr = '0;
    int            nb = 0, last_nb = 0, frames = 0;
    int            cyc = 0, busy_until = 0, fall_cyc = 0, last_gap = 0, last_edge = 0;
    int            r6_bad = 0, r11_bad = 0;
    logic          wen = 1'b0, rd_active = 1'b0, rd_bit = 1'b0, stuck = 1'b0;
    logic [7:0]    rd_sr = 8'h00;
    logic          p_cs = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0;
    logic [1:0]    m_opc;
    logic [AW-1:0] m_a;
    logic [7:0]    m_d;

    assign sdi = cs & (rd_active ? rd_bit : ((cyc >= busy_until) && !stuck));

    initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk && p_sclk && (sdo != p_sdo)) r6_bad = r6_bad + 1;
        if (cs && !p_cs) begin
            fr = '0; nb = 0; rd_active = 1'b0;
            last_gap = cyc - fall_cyc; last_edge = cyc;
        end
        if (cs && (sclk != p_sclk)) begin
            if (cyc - last_edge != DIV) r11_bad = r11_bad + 1;
            last_edge = cyc;
        end
        if (!cs && sclk) r11_bad = r11_bad + 1;
        if (cs && sclk && !p_sclk) begin
            fr = {fr[FW-2:0], sdo}; nb = nb + 1;
            if (nb == CW && fr[CW-2:CW-3] == 2'b10) begin
                rd_sr = mem[fr[AW-1:0]]; rd_active = 1'b1;
            end
        end
        if (cs && !sclk && p_sclk && rd_active) begin
            rd_bit = rd_sr[7]; rd_sr = {rd_sr[6:0], 1'b0};
        end
        if (!cs && p_cs) begin
            fall_cyc = cyc; rd_active = 1'b0;
            if (nb > 0) begin
                frames = frames + 1; last_fr = fr; last_nb = nb;
                if (nb == FW) begin
                    m_opc = fr[FW-2:FW-3]; m_a = fr[AW+7:8]; m_d = fr[7:0];
                end else begin
                    m_opc = fr[CW-2:CW-3]; m_a = fr[AW-1:0]; m_d = 8'h00;
                end
                if (m_opc == 2'b00 && m_a[AW-1:AW-2] == 2'b11) wen = 1'b1;
                if (m_opc == 2'b00 && m_a[AW-1:AW-2] == 2'b00) wen = 1'b0;
                if (wen && nb == FW && m_opc == 2'b01) begin
                    mem[m_a] = m_d; busy_until = cyc + BSY;
                end
                if (wen && nb == CW && m_opc == 2'b11) begin
                    mem[m_a] = 8'hFF; busy_until = cyc + BSY;
                end
                if (wen && m_opc == 2'b00 && m_a[AW-1:AW-2] == 2'b01 && nb == FW) begin
                    for (int i = 0; i < (1 << AW); i++) mem[i] = m_d;
                    busy_until = cyc + BSY;
                end
                if (wen && m_opc == 2'b00 && m_a[AW-1:AW-2] == 2'b10 && nb == CW) begin
                    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
                    busy_until = cyc + BSY;
                end
            end
        end
        p_cs = cs; p_sclk = sclk; p_sdo = sdo;
    end

    // ---------------- helpers ----------------------------------------
    task automatic check_eq(input string tag, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected frame, right-aligned, built from R2/R4/R5.
    function automatic logic [FW-1:0] exp_frame(input int op, input logic [AW-1:0] a,
                                                input logic [7:0] d);
        logic [AW-3:0] z;
        z = '0;
        case (op)
            0:       return {1'b1, 2'b10, a, 8'h00};
            1:       return {1'b1, 2'b01, a, d};
            2:       return {8'h00, 1'b1, 2'b11, a};
            3:       return {8'h00, 1'b1, 2'b00, 2'b11, z};
            4:       return {8'h00, 1'b1, 2'b00, 2'b00, z};
            5:       return {1'b1, 2'b00, 2'b01, z, d};
            default: return {8'h00, 1'b1, 2'b00, 2'b10, z};
        endcase
    endfunction

    function automatic int exp_len(input int op);
        return (op == 0 || op == 1 || op == 5) ? FW : CW;
    endfunction

    int start_cyc, done_cyc;

    task automatic issue(input int op, input logic [AW-1:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_wdata = d;
        start_cyc = cyc;
        @(negedge clk);
        cmd_go = 1'b0;
        check_eq("R9", "busy after accepted go", busy, 1);
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) check_eq("R9", "busy never cleared", 1, 0);
        done_cyc = cyc;
        @(negedge clk);
    endtask

    task automatic run_frame(input string tag, input int op, input logic [AW-1:0] a,
                             input logic [7:0] d);
        issue(op, a, d);
        check_eq("R3", "clock count", last_nb, exp_len(op));
        check_eq(tag, "frame bits", last_fr, exp_frame(op, a, d));
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [7:0] exp);
        run_frame("R5", 0, a, 8'h00);
        check_eq("R5", "rdata", rdata, exp);
    endtask

    task automatic t_prog(input string tag, input int op, input logic [AW-1:0] a,
                          input logic [7:0] d);
        run_frame(tag, op, a, d);
        check_eq("R7", "deselect gap >= one period", last_gap >= 2 * DIV, 1);
        check_eq("R7", "busy held until ready", done_cyc >= busy_until, 1);
        check_eq("R8", "no timeout", timeout, 0);
    endtask

    task automatic t_busy_ignore();
        int f0, n;
        f0 = frames;
        @(negedge clk); cmd_go = 1'b1; cmd_op = 3'd0; cmd_addr = 9'h0F0;
        @(negedge clk); cmd_go = 1'b0;
        repeat (5) @(negedge clk);
        cmd_go = 1'b1; cmd_op = 3'd1; cmd_addr = 9'h0F0; cmd_wdata = 8'h12;
        @(negedge clk); cmd_go = 1'b0;
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        repeat (30) @(negedge clk);
        check_eq("R9", "one frame only", frames - f0, 1);
        check_eq("R9", "frame is the READ", last_fr, exp_frame(0, 9'h0F0, 8'h00));
        check_eq("R9", "busy stays low", busy, 0);
        check_eq("R9", "rdata", rdata, 8'hFF);
    endtask

    task automatic t_reserved();
        int f0;
        f0 = frames;
        @(negedge clk); cmd_go = 1'b1; cmd_op = 3'd7; cmd_addr = 9'h1FF;
        @(negedge clk); cmd_go = 1'b0;
        check_eq("R10", "busy", busy, 0);
        repeat (20) @(negedge clk);
        check_eq("R10", "cs", cs, 0);
        check_eq("R10", "no frame", frames - f0, 0);
    endtask

    task automatic t_timeout();
        stuck = 1'b1;
        issue(1, 9'h033, 8'h5A);
        check_eq("R8", "timeout set", timeout, 1);
        check_eq("R8", "cs low", cs, 0);
        check_eq("R8", "poll budget spent", done_cyc - start_cyc >= TO, 1);
        stuck = 1'b0;
        issue(3, '0, 8'h00);
        check_eq("R8", "timeout cleared by next command", timeout, 0);
    endtask

    // ---------------- main sequence ----------------------------------
    initial begin
        repeat (4) @(negedge clk);
        check_eq("R1", "cs", cs, 0);
        check_eq("R1", "sclk", sclk, 0);
        check_eq("R1", "mosi", sdo, 0);
        check_eq("R1", "busy", busy, 0);
        check_eq("R1", "timeout", timeout, 0);
        check_eq("R1", "rdata", rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_frame("R2", 3, 9'h0AB, 8'h00);
        t_prog("R4", 1, 9'h1A5, 8'h3C);
        t_read(9'h1A5, 8'h3C);
        t_prog("R2", 2, 9'h1A5, 8'h00);
        t_read(9'h1A5, 8'hFF);
        t_prog("R4", 1, 9'h0F0, 8'hA7);
        t_prog("R4", 5, 9'h123, 8'h55);
        t_read(9'h0F0, 8'h55);
        t_prog("R2", 6, 9'h000, 8'h00);
        t_read(9'h0F0, 8'hFF);
        t_busy_ignore();
        t_reserved();
        run_frame("R2", 4, 9'h1FF, 8'h00);
        issue(1, 9'h010, 8'h99);
        t_read(9'h010, 8'hFF);
        run_frame("R2", 3, 9'h000, 8'h00);
        t_timeout();

        check_eq("R6", "mosi changes while sclk high", r6_bad, 0);
        check_eq("R11", "sclk half-period errors", r11_bad, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule